// File: doc/BRIEF.md
# Display Refresh Memory with Typewriter and Calculator Entry

This block stores one byte per digit for a multiplexed display of up to sixteen digits. A host processor fills the memory through a simple strobe interface. The display refresh logic presents a 4-bit digit number and gets that digit's byte back in the same cycle. The block also drives an active-low blanking output, which dims the display while the digit number moves on to the next digit and while a clear operation runs.

Host writes work in one of two entry styles. In typewriter style each byte goes to the location held in an address register. That register can be loaded by a separate command strobe and can step forward after every access. In calculator style the address register plays no part: every new byte lands in the rightmost digit, location 15, and the older digits each move one place toward location 0. A clear command overwrites all sixteen locations with a host-chosen blank code, one location per cycle. Host writes are refused until the clear has finished.

Top module: `dispRam`

## Requirements
- R1: After reset all sixteen bytes read 0, the address register is 0, `fillBusy` is low, and `blankN` is high while `digitCnt` stays 0.
- R2: With `rightEntry` low, an accepted `wrEn` stores `wrData` at the location named by the address register.
- R3: With `autoInc` high, the address register steps by one after every `rdEn`, and after every accepted typewriter-style write, and it wraps from 15 to 0. With `autoInc` low the register holds its value.
- R4: `addrLoad` copies `addrIn` into the address register. It beats a same-cycle increment, and a same-cycle write still uses the old address.
- R5: With `rightEntry` high, an accepted write moves location k+1 into location k for every k from 0 to 14 and puts `wrData` in location 15. The address register does not change.
- R6: `rdData` always shows the byte at the address register and `digitByte` the byte at `digitCnt`, with no clock delay.
- R7: `blankCmd` while idle captures `blankCode`, raises `fillBusy` for exactly 16 cycles and writes the code to locations 0 to 15 in turn. `blankCmd` while busy is ignored.
- R8: `wrEn` is ignored in the cycle `blankCmd` starts a fill and in every cycle with `fillBusy` high. Reads and address loads still act.
- R9: `blankN` is low in any cycle where `digitCnt` differs from its value in the previous cycle. It then stays low until BLANK_TICKS `tick` pulses have arrived after that cycle.
- R10: `blankN` is low in every cycle with `fillBusy` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Host data write strobe |
| rdEn | input | 1 | Host data read strobe (advances the address when auto-increment is on) |
| wrData | input | 8 | Host write byte |
| rdData | output | 8 | Byte at the address register |
| addrLoad | input | 1 | Load address command strobe |
| addrIn | input | 4 | Address for `addrLoad` |
| autoInc | input | 1 | Auto-increment enable |
| rightEntry | input | 1 | 1 = calculator style, 0 = typewriter style |
| blankCmd | input | 1 | Start the clear-fill |
| blankCode | input | 8 | Byte written by the clear-fill |
| fillBusy | output | 1 | Clear-fill in progress |
| digitCnt | input | 4 | Digit now being refreshed |
| tick | input | 1 | Internal timing pulse for the blanking timer |
| digitByte | output | 8 | Byte for `digitCnt` |
| blankN | output | 1 | Active-low display blanking |

## Verification
A wrong address register shows up on `rdData` in the same cycle, because the read path has no register. A wrong write address or a shift that drops a byte shows up on `digitByte` as soon as the scan reaches the affected digit. The bench runs a full digit sweep after each phase, so such an error appears within sixteen cycles. A fill counter or blanking timer that is off by one shows up at once on `fillBusy` or `blankN`, which the bench compares with its model on every clock.

// File: rtl/dispRamPkg.sv
package dispRamPkg;
  localparam int DIG_N  = 16;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = $clog2(DIG_N);

  typedef struct packed {
    logic              we;     // store data at addr
    logic              shift;  // calculator-style shift with data at top
    logic [ADDR_W-1:0] addr;
    logic [BYTE_W-1:0] data;
  } memStrobe_t;
endpackage

// File: rtl/dispRamCtrl.sv
module dispRamCtrl
  import dispRamPkg::*;
#(
  parameter int BLANK_TICKS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              addrLoad,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              autoInc,
  input  logic              rightEntry,
  input  logic              blankCmd,
  input  logic [BYTE_W-1:0] blankCode,
  input  logic [ADDR_W-1:0] digitCnt,
  input  logic              tick,
  output logic [ADDR_W-1:0] addrQ,
  output logic              fillBusy,
  output logic              switchBlank,
  output memStrobe_t        st
);
  localparam int TW = (BLANK_TICKS < 2) ? 1 : $clog2(BLANK_TICKS + 1);
  localparam logic [TW-1:0] TICK_LOAD = TW'(BLANK_TICKS);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DIG_N - 1);

  logic [ADDR_W-1:0] fillIdx;
  logic [BYTE_W-1:0] codeQ;
  logic [ADDR_W-1:0] prevDigit;
  logic [TW-1:0]     swCnt;
  logic              wrOk;
  logic              digitMoved;
  logic              stepAddr;

  assign wrOk       = wrEn && !fillBusy && !blankCmd;
  assign digitMoved = (digitCnt != prevDigit);
  assign stepAddr   = autoInc && (rdEn || (wrOk && !rightEntry));

  always_comb begin
    st.we    = fillBusy || (wrOk && !rightEntry);
    st.shift = wrOk && rightEntry;
    st.addr  = fillBusy ? fillIdx : addrQ;
    st.data  = fillBusy ? codeQ : wrData;
  end

  // host address register
  always_ff @(posedge clk) begin
    if (!rstN)          addrQ <= '0;
    else if (addrLoad)  addrQ <= addrIn;
    else if (stepAddr)  addrQ <= addrQ + 1'b1;
  end

  // clear-fill sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillBusy <= 1'b0;
      fillIdx  <= '0;
      codeQ    <= '0;
    end else if (fillBusy) begin
      fillIdx <= fillIdx + 1'b1;
      if (fillIdx == LAST) fillBusy <= 1'b0;
    end else if (blankCmd) begin
      fillBusy <= 1'b1;
      fillIdx  <= '0;
      codeQ    <= blankCode;
    end
  end

  // digit-switch blanking timer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevDigit <= '0;
      swCnt     <= '0;
    end else begin
      prevDigit <= digitCnt;
      if (digitMoved)              swCnt <= TICK_LOAD;
      else if (tick && swCnt != 0) swCnt <= swCnt - 1'b1;
    end
  end

  assign switchBlank = digitMoved || (swCnt != 0);

  p_addr_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!addrLoad && autoInc && rdEn && addrQ == LAST) |=> (addrQ == '0));

  p_load_wins_r4: assert property (@(posedge clk) disable iff (!rstN)
    addrLoad |=> (addrQ == $past(addrIn)));

  p_fill_len_r7: assert property (@(posedge clk) disable iff (!rstN)
    (fillBusy && fillIdx == LAST) |=> !fillBusy);

  p_no_host_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    fillBusy |-> (!st.shift && st.addr == fillIdx && st.data == codeQ));

  p_switch_blank_r9: assert property (@(posedge clk) disable iff (!rstN)
    (digitMoved && BLANK_TICKS > 0) |=> switchBlank);
endmodule

// File: rtl/dispRamData.sv
module dispRamData
  import dispRamPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  memStrobe_t        st,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [ADDR_W-1:0] digitCnt,
  output logic [BYTE_W-1:0] rdData,
  output logic [BYTE_W-1:0] digitByte
);
  logic [BYTE_W-1:0] mem [DIG_N];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DIG_N; i++) mem[i] <= '0;
    end else if (st.shift) begin
      for (int i = 0; i < DIG_N - 1; i++) mem[i] <= mem[i+1];
      mem[DIG_N-1] <= st.data;
    end else if (st.we) begin
      mem[st.addr] <= st.data;
    end
  end

  assign rdData    = mem[rdAddr];
  assign digitByte = mem[digitCnt];

  p_left_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (st.we && !st.shift) |=> (mem[$past(st.addr)] == $past(st.data)));

  p_right_shift_r5: assert property (@(posedge clk) disable iff (!rstN)
    st.shift |=> (mem[DIG_N-1] == $past(st.data) && mem[0] == $past(mem[1])));
endmodule

// File: rtl/dispRam.sv
module dispRam
  import dispRamPkg::*;
#(
  parameter int BLANK_TICKS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  input  logic              addrLoad,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              autoInc,
  input  logic              rightEntry,
  input  logic              blankCmd,
  input  logic [BYTE_W-1:0] blankCode,
  output logic              fillBusy,
  input  logic [ADDR_W-1:0] digitCnt,
  input  logic              tick,
  output logic [BYTE_W-1:0] digitByte,
  output logic              blankN
);
  memStrobe_t        st;
  logic [ADDR_W-1:0] addrQ;
  logic              switchBlank;

  dispRamCtrl #(.BLANK_TICKS(BLANK_TICKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData),
    .addrLoad(addrLoad), .addrIn(addrIn), .autoInc(autoInc),
    .rightEntry(rightEntry), .blankCmd(blankCmd), .blankCode(blankCode),
    .digitCnt(digitCnt), .tick(tick), .addrQ(addrQ), .fillBusy(fillBusy),
    .switchBlank(switchBlank), .st(st)
  );

  dispRamData u_data (
    .clk(clk), .rstN(rstN), .st(st), .rdAddr(addrQ), .digitCnt(digitCnt),
    .rdData(rdData), .digitByte(digitByte)
  );

  assign blankN = !(fillBusy || switchBlank);

  p_fill_blanks_r10: assert property (@(posedge clk) disable iff (!rstN)
    fillBusy |-> !blankN);
endmodule

// File: tb/test_dispRam.sv
module test_dispRam;
  localparam int BT = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 0, rdEn = 0, addrLoad = 0, autoInc = 0, rightEntry = 0;
  logic blankCmd = 0, tick = 0;
  logic [7:0] wrData = 0, blankCode = 0;
  logic [3:0] addrIn = 0, digitCnt = 0;
  logic [7:0] rdData, digitByte;
  logic fillBusy, blankN;

  int checks = 0, fails = 0;

  // behavioural reference state
  int mMem [16];
  int mAddr, mFi, mCode, mPrev, mSw;
  bit mBusy;

  always #4 clk = ~clk;

  dispRam #(.BLANK_TICKS(BT)) i_dispRam (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData),
    .rdData(rdData), .addrLoad(addrLoad), .addrIn(addrIn), .autoInc(autoInc),
    .rightEntry(rightEntry), .blankCmd(blankCmd), .blankCode(blankCode),
    .fillBusy(fillBusy), .digitCnt(digitCnt), .tick(tick),
    .digitByte(digitByte), .blankN(blankN)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (mMem[i]) mMem[i] = 0;
      mAddr = 0; mFi = 0; mCode = 0; mPrev = 0; mSw = 0; mBusy = 0;
    end else begin
      bit wrOk;
      wrOk = wrEn && !mBusy && !blankCmd;
      if (int'(digitCnt) != mPrev) mSw = BT;
      else if (tick && mSw > 0) mSw = mSw - 1;
      mPrev = int'(digitCnt);
      if (mBusy) begin
        mMem[mFi] = mCode;
        if (mFi == 15) mBusy = 0;
        mFi = (mFi + 1) % 16;
      end else if (blankCmd) begin
        mBusy = 1; mFi = 0; mCode = int'(blankCode);
      end else if (wrOk) begin
        if (rightEntry) begin
          for (int k = 0; k < 15; k++) mMem[k] = mMem[k+1];
          mMem[15] = int'(wrData);
        end else mMem[mAddr] = int'(wrData);
      end
      if (addrLoad) mAddr = int'(addrIn);
      else if (autoInc && (rdEn || (wrOk && !rightEntry))) mAddr = (mAddr + 1) % 16;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmpAll();
    chk("R6 rdData", int'(rdData), mMem[mAddr]);
    chk("R6 digitByte", int'(digitByte), mMem[digitCnt]);
    chk("R7 fillBusy", int'(fillBusy), int'(mBusy));
    chk("R9/R10 blankN", int'(blankN),
        int'(!(mBusy || mSw != 0 || int'(digitCnt) != mPrev)));
  endtask

  task automatic idle();
    wrEn = 0; rdEn = 0; addrLoad = 0; blankCmd = 0; tick = 0;
  endtask

  // drive after the falling edge, compare, then let the rising edge act
  task automatic step();
    #1 cmpAll();
    @(negedge clk);
  endtask

  task automatic sweep();
    for (int d = 0; d < 16; d++) begin
      idle(); digitCnt = 4'(d); step();
    end
  endtask

  initial begin
    fork
      begin
        #1500000;
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    join_none

    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1 rdData after reset", int'(rdData), 0);
    chk("R1 fillBusy after reset", int'(fillBusy), 0);
    chk("R1 blankN after reset", int'(blankN), 1);
    @(negedge clk);

    // R4: load address 14, R2/R3: auto-increment writes wrap
    idle(); addrLoad = 1; addrIn = 14; step();
    idle(); autoInc = 1;
    for (int k = 0; k < 3; k++) begin wrEn = 1; wrData = 8'(8'h40 + k); step(); end
    idle(); #1 chk("R3 wrap to address 1", int'(rdData), 0);
    chk("R2 byte at 0 after wrap", int'(mMem[0]), 8'h42);
    @(negedge clk);
    idle(); addrLoad = 1; addrIn = 15; step();
    idle(); #1 chk("R2 read back addr 15", int'(rdData), 8'h41);
    @(negedge clk);
    idle(); rdEn = 1; step();
    idle(); #1 chk("R3 read increments 15->0", int'(rdData), 8'h42);
    @(negedge clk);
    // R3 without autoInc, R4 load beats increment
    idle(); autoInc = 0; wrEn = 1; wrData = 8'h77; step();
    idle(); wrEn = 1; wrData = 8'h78; step();
    idle(); #1 chk("R3 no increment holds addr 0", int'(rdData), 8'h78);
    @(negedge clk);
    idle(); autoInc = 1; wrEn = 1; wrData = 8'h55; addrLoad = 1; addrIn = 9; step();
    idle(); #1 chk("R4 load wins over increment", int'(rdData), 0);
    chk("R4 write used old address", int'(mMem[0]), 8'h55);
    @(negedge clk);
    sweep();

    // R5 right entry
    idle(); rightEntry = 1;
    for (int k = 0; k < 4; k++) begin wrEn = 1; wrData = 8'(8'h10 + k); step(); end
    idle(); digitCnt = 15; step();
    #1 chk("R5 newest at digit 15", int'(digitByte), 8'h13);
    digitCnt = 12; #1 chk("R5 oldest shifted to 12", int'(digitByte), 8'h10);
    chk("R5 address unchanged", int'(rdData), mMem[9]);
    @(negedge clk);
    rightEntry = 0;
    sweep();

    // R9 switch blanking with ticks
    idle(); digitCnt = 3; step();
    for (int k = 0; k < 6; k++) begin idle(); tick = 1; step(); end
    idle(); #1 chk("R9 blank released after ticks", int'(blankN), 1);
    @(negedge clk);

    // R7/R8/R10 fill
    idle(); blankCmd = 1; blankCode = 8'hA5; wrEn = 1; wrData = 8'h01; step();
    for (int k = 0; k < 16; k++) begin
      idle(); wrEn = 1; wrData = 8'h02; blankCmd = (k == 4); step();
    end
    idle(); #1 chk("R7 busy ends after 16", int'(fillBusy), 0);
    chk("R8 write during fill dropped", int'(rdData), 8'hA5);
    @(negedge clk);
    sweep();

    // mixed traffic compared on every clock
    for (int n = 0; n < 600; n++) begin
      int r;
      r = int'($urandom);
      idle();
      wrEn = r[0] | r[1]; rdEn = r[2]; addrLoad = (r[5:3] == 0);
      autoInc = r[6]; rightEntry = r[7] & r[8]; blankCmd = (r[15:10] == 0);
      tick = r[9]; wrData = r[23:16]; blankCode = r[31:24];
      addrIn = r[27:24]; if (r[12:11] == 0) digitCnt = r[19:16];
      step();
    end
    idle(); sweep();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule